// File: doc/BRIEF.md
# Sixteen-Pin I/O Port with Per-Pin Interrupt Triggers

This block is a general-purpose I/O port of sixteen pins, each configured on its own. Each pin can be an output, a plain input, or an input that raises an interrupt. The pad is seen as three vectors: the sampled input, the driven value and the output enable. Software programs the port through a small word-wide register bus. A write takes effect at the clock edge. A read returns its data one cycle later, flagged by a valid strobe.

Every input passes through a two-flop synchroniser. The port keeps the synchronised value and the value one cycle older, and compares the two to find edges. Each pin picks one of five triggers: level high, level low, rising edge, falling edge, or either edge. Level triggers give a live status that follows the synchronised input. Edge triggers use a per-pin capture machine with two states. In `EC_IDLE` nothing is pending. The transition *latch*, taken when a qualifying edge is seen on an armed pin, moves the machine to `EC_HELD`. The transition *release*, taken when software writes a 1 to that pin's status bit and no new edge arrives in the same cycle, returns it to `EC_IDLE`. An interrupt controller receives the per-pin masked status vector and a single combined line.

Register map (3-bit address, data one bit per pin):

| Addr | Name | Access | Meaning per bit |
|---|---|---|---|
| 0 | DIR | rw | 1 = pin is an output |
| 1 | DOUT | rw | value driven on the pin |
| 2 | DIN | ro | synchronised pin input |
| 3 | IEN | rw | 1 = input pin raises interrupts |
| 4 | EDGE | rw | 0 = level trigger, 1 = edge trigger |
| 5 | POL | rw | level: 1 high / 0 low; edge: 1 rising / 0 falling |
| 6 | BOTH | rw | with EDGE=1: 1 = either edge, POL ignored |
| 7 | STAT | r / w1c | raw status; writing 1 releases a held edge bit |

Top module: `gpio16_port`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0, `irq_vec` is 0 and `irq` is 0.
- R2: Bit i of DIR (addr 0) set to 1 drives `pin_oe[i]` high, and 0 drives it low. `pin_out` always equals DOUT (addr 1).
- R3: DIN (addr 2) reads `pin_in` through two flops. A change on `pin_in` applied before rising edge k does not show on level status after edge k, and shows after edge k+1.
- R4: EDGE=0 and POL=1 give active-high level triggering. Status is 1 while the synchronised input is 1 and drops as soon as the input falls, with no stickiness.
- R5: EDGE=0 and POL=0 give active-low level triggering. Status is 1 while the synchronised input is 0.
- R6: EDGE=1, BOTH=0 and POL=1 give rising-edge triggering. A rising edge sets a status bit that stays set after the input returns low. A falling edge sets nothing.
- R7: EDGE=1, BOTH=0 and POL=0 give falling-edge triggering. A falling edge sets a sticky status bit. A rising edge sets nothing.
- R8: EDGE=1 and BOTH=1 make either edge set the sticky status, whatever POL holds.
- R9: STAT (addr 7) reads the per-pin status. Writing STAT releases exactly the edge bits written as 1 and leaves the other bits as they were.
- R10: A pin raises interrupts only when DIR=0 and IEN (addr 3)=1. Edges seen while a pin is not armed are not captured. An output pin never shows a bit in `irq_vec`.
- R11: `irq` is 1 exactly when some bit of `irq_vec` is 1.
- R12: If a qualifying edge falls in the same cycle as a STAT write that releases that pin, the status bit stays set.
- R13: `bus_rvalid` is high in the cycle after each cycle with `bus_rd` high and low otherwise, and `bus_rdata` then holds the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | 3 | register address |
| bus_wdata | input | NPINS | write data |
| bus_rdata | output | NPINS | read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | read data valid |
| pin_in | input | NPINS | pad input values |
| pin_out | output | NPINS | pad output values |
| pin_oe | output | NPINS | pad output enables |
| irq_vec | output | NPINS | per-pin masked interrupt status |
| irq | output | 1 | combined interrupt |

## Verification
The hardest case to reach from the ports is a new edge arriving in the very cycle a release write lands. The edge is only seen two clock edges after the pin changes, so the bench counts cycles from the pin change. It puts the STAT write on the bus so that the write is taken at the same edge that samples the comparison of synchronised and delayed input. It uses a pin in either-edge mode that is already held, so a wrong priority shows up as a dropped bit. The bench also checks the synchroniser one cycle at a time, showing that level status is still absent after one edge and present after two.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

    typedef enum logic [2:0] {
        TRG_LVL_HI = 3'd0,
        TRG_LVL_LO = 3'd1,
        TRG_RISE   = 3'd2,
        TRG_FALL   = 3'd3,
        TRG_BOTH   = 3'd4
    } trig_e;

    typedef enum logic {
        EC_IDLE = 1'b0,
        EC_HELD = 1'b1
    } cap_e;

    localparam logic [2:0] A_DIR  = 3'd0;
    localparam logic [2:0] A_DOUT = 3'd1;
    localparam logic [2:0] A_DIN  = 3'd2;
    localparam logic [2:0] A_IEN  = 3'd3;
    localparam logic [2:0] A_EDGE = 3'd4;
    localparam logic [2:0] A_POL  = 3'd5;
    localparam logic [2:0] A_BOTH = 3'd6;
    localparam logic [2:0] A_STAT = 3'd7;

    function automatic trig_e trig_decode(input logic is_edge, input logic pol, input logic both);
        if (!is_edge)
            return pol ? TRG_LVL_HI : TRG_LVL_LO;
        else if (both)
            return TRG_BOTH;
        else
            return pol ? TRG_RISE : TRG_FALL;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            warm_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
            if (warm_q != 2'd2)
                warm_q <= warm_q + 2'd1;
        end
    end

    assign q = s2_q;

    // R3: output is the input delayed by exactly two edges
    p_two_flop_r3: assert property (@(posedge clk) disable iff (!rst_n || warm_q != 2'd2)
        q == $past(d, 2));

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio16_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl,
    input  logic  armed,
    input  trig_e trig,
    input  logic  clr,
    output logic  status
);
    logic prev_q;
    cap_e st_q, st_d;
    logic edge_hit, lvl_match, is_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        is_edge   = 1'b0;
        lvl_match = 1'b0;
        edge_hit  = 1'b0;
        unique case (trig)
            TRG_LVL_HI: lvl_match = lvl;
            TRG_LVL_LO: lvl_match = ~lvl;
            TRG_RISE: begin
                is_edge  = 1'b1;
                edge_hit = armed & lvl & ~prev_q;
            end
            TRG_FALL: begin
                is_edge  = 1'b1;
                edge_hit = armed & ~lvl & prev_q;
            end
            TRG_BOTH: begin
                is_edge  = 1'b1;
                edge_hit = armed & (lvl ^ prev_q);
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EC_IDLE;
        else        st_q <= st_d;
    end

    // next state: latch / release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EC_IDLE: if (edge_hit)         st_d = EC_HELD;
            EC_HELD: if (clr && !edge_hit) st_d = EC_IDLE;
            default: st_d = EC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        if (is_edge) status = (st_q == EC_HELD);
        else         status = armed & lvl_match;
    end

    // R6: a qualifying edge is captured
    p_edge_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> st_q == EC_HELD);
    // R9: a release write without an edge frees the bit
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == EC_HELD && clr && !edge_hit) |=> st_q == EC_IDLE);
    // R12: capture beats release
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && clr) |=> st_q == EC_HELD);
    // R10: no capture while disarmed
    p_disarmed_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && st_q == EC_IDLE) |=> st_q == EC_IDLE);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio16_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [2:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rdata,
    output logic             rvalid,
    input  logic [NPINS-1:0] din,
    input  logic [NPINS-1:0] status,
    output logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] dout,
    output logic [NPINS-1:0] ien,
    output logic [NPINS-1:0] edg,
    output logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] both,
    output logic [NPINS-1:0] clr
);
    logic [NPINS-1:0] rmux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir  <= '0;
            dout <= '0;
            ien  <= '0;
            edg  <= '0;
            pol  <= '0;
            both <= '0;
        end else if (wr) begin
            case (addr)
                A_DIR:  dir  <= wdata;
                A_DOUT: dout <= wdata;
                A_IEN:  ien  <= wdata;
                A_EDGE: edg  <= wdata;
                A_POL:  pol  <= wdata;
                A_BOTH: both <= wdata;
                default: ;
            endcase
        end
    end

    assign clr = (wr && addr == A_STAT) ? wdata : '0;

    always_comb begin
        unique case (addr)
            A_DIR:   rmux = dir;
            A_DOUT:  rmux = dout;
            A_DIN:   rmux = din;
            A_IEN:   rmux = ien;
            A_EDGE:  rmux = edg;
            A_POL:   rmux = pol;
            A_BOTH:  rmux = both;
            A_STAT:  rmux = status;
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= rmux;
        end
    end

    // R13: read strobe answered exactly one cycle later
    p_rvalid_rise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    p_rvalid_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
    import gpio16_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic             bus_rvalid,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] irq_vec,
    output logic             irq
);
    logic [NPINS-1:0] din_s, status, dir, dout, ien, edg, pol, both, clr, armed;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_s)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .rvalid(bus_rvalid),
        .din(din_s), .status(status), .dir(dir), .dout(dout), .ien(ien),
        .edg(edg), .pol(pol), .both(both), .clr(clr)
    );

    assign armed = ~dir & ien;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_detect u_det (
            .clk(clk), .rst_n(rst_n), .lvl(din_s[i]), .armed(armed[i]),
            .trig(trig_decode(edg[i], pol[i], both[i])), .clr(clr[i]),
            .status(status[i])
        );

        // R10: an output pin never reports an interrupt
        p_out_pin_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[i] |-> !irq_vec[i]);
    end

    assign pin_oe  = dir;
    assign pin_out = dout;
    assign irq_vec = status & armed;
    assign irq     = |irq_vec;

endmodule

// File: tb/sim_gpio16_port.sv
module sim_gpio16_port;
    import gpio16_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe, irq_vec;
    logic        bus_rvalid, irq;

    int applied = 0, miscompares = 0;
    bit done = 0;

    typedef struct { logic [2:0] a; logic [15:0] exp; string tag; } rd_item_t;
    rd_item_t expq[$];

    always #10 clk = ~clk;

    gpio16_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_vec(irq_vec), .irq(irq)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: push the expected item, then issue the read
    task automatic rd(logic [2:0] a, logic [15:0] exp, string tag);
        rd_item_t it;
        it.a = a; it.exp = exp; it.tag = tag;
        expq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pins(logic [15:0] v);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    // monitor: pop and compare each read response
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rvalid) begin
                if (expq.size() == 0) begin
                    chk("R13 unexpected rvalid", 16'h1, 16'h0);
                end else begin
                    rd_item_t it;
                    it = expq.pop_front();
                    chk(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got %h expected %h", 16'h0, 16'h1);
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 16'h0);
        chk("R1 irq_vec", irq_vec, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
        rd(A_DIR, 16'h0, "R1 DIR");
        rd(A_IEN, 16'h0, "R1 IEN");
        rd(A_EDGE, 16'h0, "R1 EDGE");
        rd(A_STAT, 16'h0, "R1 STAT");

        // R2 direction and output data
        wr(A_DIR, 16'h00FF);
        wr(A_DOUT, 16'hA5A5);
        chk("R2 pin_oe", pin_oe, 16'h00FF);
        chk("R2 pin_out", pin_out, 16'hA5A5);
        rd(A_DIR, 16'h00FF, "R2 DIR read");
        rd(A_DOUT, 16'hA5A5, "R13 DOUT read");
        wr(A_DIR, 16'h0000);
        chk("R2 pin_oe off", pin_oe, 16'h0);

        // R3 input readback
        pins(16'h1230);
        rd(A_DIN, 16'h1230, "R3 DIN");
        pins(16'h0000);

        // R3/R4 synchroniser latency and active-high level
        wr(A_POL, 16'h0001);
        wr(A_IEN, 16'h0001);
        pin_in = 16'h0001;
        @(negedge clk);
        chk("R3 one edge", irq_vec, 16'h0000);
        @(negedge clk);
        chk("R3 two edges", irq_vec, 16'h0001);
        chk("R4 level high", {15'h0, irq}, 16'h1);
        pins(16'h0000);
        chk("R4 not sticky", irq_vec, 16'h0000);

        // R5 active-low level on pin1
        wr(A_IEN, 16'h0003);
        @(negedge clk);
        chk("R5 low active", irq_vec, 16'h0002);
        pins(16'h0002);
        chk("R5 high idle", irq_vec, 16'h0000);
        pins(16'h0000);
        wr(A_IEN, 16'h0000);
        chk("R10 disabled level", irq_vec, 16'h0000);

        // R6 rising edge on pin2
        wr(A_EDGE, 16'h0004);
        wr(A_POL, 16'h0005);
        wr(A_IEN, 16'h0004);
        pins(16'h0004);
        chk("R6 rise set", irq_vec, 16'h0004);
        pins(16'h0000);
        chk("R6 sticky", irq_vec, 16'h0004);
        rd(A_STAT, 16'h0004, "R9 STAT read");
        pins(16'h0004);
        wr(A_STAT, 16'h0004);
        @(negedge clk);
        chk("R9 cleared", irq_vec, 16'h0000);
        pins(16'h0000);
        chk("R6 fall ignored", irq_vec, 16'h0000);

        // R7 falling edge on pin3
        wr(A_EDGE, 16'h000C);
        wr(A_IEN, 16'h0008);
        pins(16'h0008);
        chk("R7 rise ignored", irq_vec, 16'h0000);
        pins(16'h0000);
        chk("R7 fall set", irq_vec, 16'h0008);

        // R8 either edge on pin4
        wr(A_STAT, 16'hFFFF);
        wr(A_EDGE, 16'h001C);
        wr(A_BOTH, 16'h0010);
        wr(A_IEN, 16'h0018);
        chk("R9 all cleared", irq_vec, 16'h0000);
        pins(16'h0010);
        chk("R8 rise", irq_vec, 16'h0010);
        wr(A_STAT, 16'h0010);
        pins(16'h0000);
        chk("R8 fall", irq_vec, 16'h0010);

        // R9 selective release, R11 combined line
        pins(16'h0008);
        pins(16'h0000);
        chk("R9 two held", irq_vec, 16'h0018);
        wr(A_STAT, 16'h0008);
        @(negedge clk);
        chk("R9 selective", irq_vec, 16'h0010);
        chk("R11 irq one", {15'h0, irq}, 16'h1);
        wr(A_STAT, 16'h0010);
        @(negedge clk);
        chk("R11 irq none", {15'h0, irq}, 16'h0);

        // R12 edge coincides with release
        pins(16'h0010);
        chk("R12 held", irq_vec, 16'h0010);
        pin_in = 16'h0000;
        @(negedge clk);
        @(negedge clk);
        wr(A_STAT, 16'h0010);
        @(negedge clk);
        chk("R12 set wins", irq_vec, 16'h0010);
        wr(A_STAT, 16'h0010);
        @(negedge clk);
        chk("R9 release", irq_vec, 16'h0000);

        // R10 output pin and disarmed pin
        wr(A_EDGE, 16'h0060);
        wr(A_POL, 16'h0060);
        wr(A_BOTH, 16'h0000);
        wr(A_DIR, 16'h0020);
        wr(A_IEN, 16'h0020);
        chk("R2 oe pin5", pin_oe, 16'h0020);
        pins(16'h0060);
        chk("R10 output pin", irq_vec, 16'h0000);
        wr(A_DIR, 16'h0000);
        wr(A_IEN, 16'h0060);
        @(negedge clk);
        chk("R10 no late capture", irq_vec, 16'h0000);
        rd(A_STAT, 16'h0000, "R10 STAT");

        repeat (4) @(negedge clk);
        chk("R13 reads drained", 16'(expq.size()), 16'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule